// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the byte-wide register front end that a host processor sees on a simple Ethernet controller. It decodes a 5-bit offset. Offset 0 always reaches the command register. Every other offset is routed to one of several register pages, and bits 7:6 of the command register select the page. The pages hold the receive ring pointers, the remote DMA address and byte count, the transmit start page and byte count, the receive, transmit and data configuration bytes, the station address, the current receive page, the multicast filter, and the local DMA bookkeeping bytes.

The interrupt status byte and the interrupt mask byte live here. Together they drive one registered, level-sensitive interrupt line. Command writes act on the status byte at once:
- Leaving stop mode drops the reset-status bit.
- Requesting remote DMA with a zero remote count reports DMA completion straight away.
- Setting the transmit bit emits a one-cycle start pulse that carries the transmit page and length, posts the transmit-done status, and clears the transmit bit again.

Reading the top offset performs a soft reset of the whole file.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset the command register reads 0x22, interrupt status reads 0x80 (bit 7 is reset-status), the mask reads 0x00, all eight multicast bytes read 0xFF, every other register reads 0x00, and irq and tx_go are low.
- R2: Offset 0 is the command register on every page. Other offsets use page cmd[7:6]. Page 0 map: 0x01 ring first page, 0x02 ring last page, 0x03 boundary, 0x04 transmit page (write) / transmit status (read), 0x05/0x06 transmit count low/high, 0x07/0x08 remote address low/high, 0x09/0x0A remote count low/high, 0x0B receive config, 0x0C transmit config, 0x0D data config, 0x0E interrupt mask, 0x0F interrupt status. Page 1 map: 0x01-0x06 station address, 0x07 current page, 0x08-0x0F multicast bytes. Page 2 map: 0x01-0x06 local DMA bytes.
- R3: Writes to unmapped offsets are ignored, and reads of them return 0x00. Unmapped offsets are 0x10-0x1E, page 2 offsets 0x07-0x0F, and every nonzero offset on page 3.
- R4: Writing interrupt status clears each bit whose position is 1 in the low 7 bits of the written byte. Bit 7 is never cleared by this write.
- R5: irq is high exactly one cycle after the AND of status and mask, limited to bits 6:0, is nonzero.
- R6: A command write with bit 0 (stop) clear clears status bit 7. If that write also sets bit 3 (remote read) or bit 4 (remote write) while the 16-bit remote count is 0, it sets status bit 6.
- R7: A command write with bit 0 clear and bit 2 (transmit) set does four things: it pulses tx_go for one cycle with tx_page and tx_len taken from the transmit page and count registers, sets transmit status to 0x01, sets status bit 1, and stores the command with bit 2 cleared. When bit 0 is set, the command is stored as written and nothing else happens.
- R8: Each 16-bit register is written through separate low and high offsets, and each write changes only its own byte.
- R9: A read of offset 0x1F returns 0x00 and restores the full reset state of R1. A write to offset 0x1F changes nothing.
- R10: A write takes effect on the clock edge that samples wr_en. rdata is registered: it is valid the cycle after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered level interrupt |
| tx_go | output | 1 | One-cycle transmit start pulse |
| tx_page | output | 8 | Transmit start page, valid with tx_go |
| tx_len | output | 16 | Transmit byte count, valid with tx_go |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Status bit 7 set while the mask is all ones. A design that fed bit 7 into the interrupt would raise irq here.
- A status write that touches bit 7. A design that let this write clear bit 7 would lose the reset-status report.
- Remote DMA requested with both a zero and a nonzero remote count. A design that ignored the count would flag completion on the wrong one.
- A transmit command given while in stop mode. A wrong design would pulse tx_go or clear the transmit bit.
- The same offset written on pages 1, 2 and 3 and then read back on page 0. Leaks across pages, and unmapped slots that keep data, show up as wrong readback.
- The interrupt line watched in the cycle right after the status change. A combinational or two-stage path shows up as the wrong latency.
- A read of 0x1F. A design that reset only part of the file would still show old ring or multicast values afterwards.

// File: rtl/nicr_pkg.sv
package nicr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int OFF_W  = ADDR_W - 1;

  // command bits
  localparam int CMD_STOP = 0;
  localparam int CMD_TX   = 2;
  localparam int CMD_RRD  = 3;
  localparam int CMD_RWR  = 4;
  localparam logic [DATA_W-1:0] CMD_INIT = 8'h22;

  // interrupt status bits
  localparam int IS_TXDONE = 1;
  localparam int IS_RDC    = 6;
  localparam int IS_RESET  = 7;
  localparam logic [DATA_W-1:0] IS_INIT  = 8'h80;
  localparam logic [DATA_W-1:0] TSR_SENT = 8'h01;

  // page 0 offsets with special meaning
  localparam logic [OFF_W-1:0] P0_TXPG  = 4'h4;
  localparam logic [OFF_W-1:0] P0_LAST  = 4'hD;
  localparam logic [OFF_W-1:0] P0_MASK  = 4'hE;
  localparam logic [OFF_W-1:0] P0_STAT  = 4'hF;
  localparam logic [OFF_W-1:0] P2_LAST  = 4'h6;
  localparam logic [ADDR_W-1:0] SOFT_RST_OFF = 5'h1F;

  // page 0 byte-file slots (offset - 1)
  localparam int S_TXPG = 3;
  localparam int S_TXLO = 4;
  localparam int S_TXHI = 5;
  localparam int S_RCLO = 8;
  localparam int S_RCHI = 9;

  localparam int P0_N = 13;
  localparam int P1_N = 15;
  localparam int P2_N = 6;
endpackage

// File: rtl/nicr_byte_file.sv
module nicr_byte_file #(
  parameter int N = 4,
  parameter int W = 8,
  parameter int IW = 4,
  parameter logic [N*W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wd,
  output logic [N*W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) q[i*W +: W] <= INIT[i*W +: W];
      else if (we && idx == IW'(i)) q[i*W +: W] <= wd;
    end
  end

  // R3/R8: contents move only on a write strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q));
endmodule

// File: rtl/nicr_cmd_unit.sv
module nicr_cmd_unit
  import nicr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              stat_we,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] wd,
  input  logic              rcnt_zero,
  input  logic [DATA_W-1:0] txpg_in,
  input  logic [15:0]       txlen_in,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] tsr_q,
  output logic              tx_go,
  output logic [DATA_W-1:0] tx_page,
  output logic [15:0]       tx_len,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_INIT;
      stat_q  <= IS_INIT;
      mask_q  <= '0;
      tsr_q   <= '0;
      tx_go   <= 1'b0;
      tx_page <= '0;
      tx_len  <= '0;
      irq     <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      irq   <= |(stat_q[6:0] & mask_q[6:0]);
      if (mask_we) mask_q <= wd;
      if (stat_we) stat_q[6:0] <= stat_q[6:0] & ~wd[6:0];
      if (cmd_we) begin
        cmd_q <= wd;
        if (!wd[CMD_STOP]) begin
          stat_q[IS_RESET] <= 1'b0;
          if ((wd[CMD_RRD] || wd[CMD_RWR]) && rcnt_zero) stat_q[IS_RDC] <= 1'b1;
          if (wd[CMD_TX]) begin
            cmd_q[CMD_TX]     <= 1'b0;
            tsr_q             <= TSR_SENT;
            stat_q[IS_TXDONE] <= 1'b1;
            tx_go             <= 1'b1;
            tx_page           <= txpg_in;
            tx_len            <= txlen_in;
          end
        end
      end
    end
  end

  // R4: bits named in a status write are zero afterwards, bit 7 unchanged
  p_stat_clear_r4: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> ((stat_q[6:0] & $past(wd[6:0])) == 7'd0) && (stat_q[7] == $past(stat_q[7])));
  // R6: leaving stop mode drops reset-status
  p_leave_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !wd[CMD_STOP]) |=> !stat_q[IS_RESET]);
  // R7: a transmit pulse comes with its side effects
  p_tx_effects_r7: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> (!cmd_q[CMD_TX] && stat_q[IS_TXDONE] && tsr_q == TSR_SENT));
  // R5: with an empty mask the interrupt stays low next cycle
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    $past(mask_q[6:0] == 7'd0) |-> !irq);
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nicr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              tx_go,
  output logic [DATA_W-1:0] tx_page,
  output logic [15:0]       tx_len
);
  localparam int P2_IW = $clog2(P2_N);
  localparam logic [P1_N*DATA_W-1:0] P1_INIT = {{8{8'hFF}}, {(P1_N-8){8'h00}}};

  logic [DATA_W-1:0] cmd_q, stat_q, mask_q, tsr_q;
  logic [P0_N*DATA_W-1:0] p0_q;
  logic [P1_N*DATA_W-1:0] p1_q;
  logic [P2_N*DATA_W-1:0] p2_q;

  logic [1:0]       page;
  logic [OFF_W-1:0] off, idx;
  logic             low_half, soft_rst, rst_all;
  logic             we_cmd, we_p0, we_p1, we_p2, we_mask, we_stat;
  logic             rcnt_zero;
  logic [DATA_W-1:0] rd_mux;

  assign page     = cmd_q[7:6];
  assign off      = addr[OFF_W-1:0];
  assign idx      = off - 4'd1;
  assign low_half = !addr[ADDR_W-1] && off != '0;
  assign soft_rst = rd_en && addr == SOFT_RST_OFF;
  assign rst_all  = rst || soft_rst;

  assign we_cmd  = wr_en && addr == '0;
  assign we_p0   = wr_en && low_half && page == 2'd0 && off <= P0_LAST;
  assign we_mask = wr_en && low_half && page == 2'd0 && off == P0_MASK;
  assign we_stat = wr_en && low_half && page == 2'd0 && off == P0_STAT;
  assign we_p1   = wr_en && low_half && page == 2'd1;
  assign we_p2   = wr_en && low_half && page == 2'd2 && off <= P2_LAST;

  assign rcnt_zero = {p0_q[S_RCHI*8 +: 8], p0_q[S_RCLO*8 +: 8]} == 16'd0;

  nicr_byte_file #(.N(P0_N), .W(DATA_W), .IW(OFF_W), .INIT('0)) u_p0 (
    .clk(clk), .rst(rst_all), .we(we_p0), .idx(idx), .wd(wdata), .q(p0_q));
  nicr_byte_file #(.N(P1_N), .W(DATA_W), .IW(OFF_W), .INIT(P1_INIT)) u_p1 (
    .clk(clk), .rst(rst_all), .we(we_p1), .idx(idx), .wd(wdata), .q(p1_q));
  nicr_byte_file #(.N(P2_N), .W(DATA_W), .IW(P2_IW), .INIT('0)) u_p2 (
    .clk(clk), .rst(rst_all), .we(we_p2), .idx(idx[P2_IW-1:0]), .wd(wdata), .q(p2_q));

  nicr_cmd_unit u_cmd (
    .clk(clk), .rst(rst_all), .cmd_we(we_cmd), .stat_we(we_stat), .mask_we(we_mask),
    .wd(wdata), .rcnt_zero(rcnt_zero), .txpg_in(p0_q[S_TXPG*8 +: 8]),
    .txlen_in({p0_q[S_TXHI*8 +: 8], p0_q[S_TXLO*8 +: 8]}),
    .cmd_q(cmd_q), .stat_q(stat_q), .mask_q(mask_q), .tsr_q(tsr_q),
    .tx_go(tx_go), .tx_page(tx_page), .tx_len(tx_len), .irq(irq));

  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = cmd_q;
    else if (low_half) begin
      case (page)
        2'd0: begin
          if (off == P0_TXPG) rd_mux = tsr_q;
          else if (off == P0_MASK) rd_mux = mask_q;
          else if (off == P0_STAT) rd_mux = stat_q;
          else for (int i = 0; i < P0_N; i++) if (idx == OFF_W'(i)) rd_mux = p0_q[i*8 +: 8];
        end
        2'd1: for (int i = 0; i < P1_N; i++) if (idx == OFF_W'(i)) rd_mux = p1_q[i*8 +: 8];
        2'd2: for (int i = 0; i < P2_N; i++) if (idx == OFF_W'(i)) rd_mux = p2_q[i*8 +: 8];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R9: the soft-reset read returns zero and leaves the command at its reset value
  p_soft_rst_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == SOFT_RST_OFF) |-> (rdata == '0 && cmd_q == CMD_INIT));
  // R10: read data only moves on a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_nic_ctl_regs.sv
`timescale 1ns/1ps
module sim_nic_ctl_regs;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tx_page;
  logic [15:0] tx_len;
  logic irq, tx_go;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nic_ctl_regs u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_go(tx_go), .tx_page(tx_page), .tx_len(tx_len));

  // {op, addr, data, expected}; op 0 write, 1 read+check, 2 idle+irq check
  localparam int NV = 63;
  localparam logic [22:0] VEC [NV] = '{
    {2'd1,5'h00,8'h00,8'h22}, {2'd1,5'h0F,8'h00,8'h80}, {2'd1,5'h0E,8'h00,8'h00}, // R1
    {2'd2,5'h00,8'h00,8'h00},                                                      // R1
    {2'd0,5'h0E,8'hFF,8'h00}, {2'd2,5'h00,8'h00,8'h00},                            // R5 bit7 excluded
    {2'd0,5'h00,8'h22,8'h00}, {2'd1,5'h0F,8'h00,8'h00},                            // R6
    {2'd0,5'h01,8'h46,8'h00}, {2'd0,5'h03,8'h4C,8'h00}, {2'd1,5'h01,8'h00,8'h46},  // R2
    {2'd0,5'h07,8'h34,8'h00}, {2'd0,5'h08,8'h12,8'h00}, {2'd0,5'h07,8'h99,8'h00},
    {2'd1,5'h08,8'h00,8'h12},                                                      // R8
    {2'd0,5'h00,8'h0A,8'h00}, {2'd1,5'h0F,8'h00,8'h40}, {2'd2,5'h00,8'h00,8'h01},  // R6 R5
    {2'd0,5'h0F,8'h40,8'h00}, {2'd2,5'h00,8'h00,8'h00},                            // R4
    {2'd0,5'h09,8'h05,8'h00}, {2'd0,5'h00,8'h12,8'h00}, {2'd1,5'h0F,8'h00,8'h00},  // R6
    {2'd0,5'h04,8'h40,8'h00}, {2'd0,5'h05,8'h3C,8'h00}, {2'd0,5'h06,8'h00,8'h00},
    {2'd0,5'h00,8'h26,8'h00}, {2'd1,5'h00,8'h00,8'h22}, {2'd1,5'h04,8'h00,8'h01},  // R7
    {2'd1,5'h0F,8'h00,8'h02}, {2'd2,5'h00,8'h00,8'h01},
    {2'd0,5'h0F,8'h82,8'h00}, {2'd1,5'h0F,8'h00,8'h00},                            // R4
    {2'd0,5'h00,8'h25,8'h00}, {2'd1,5'h00,8'h00,8'h25}, {2'd1,5'h0F,8'h00,8'h00},  // R7 stop
    {2'd0,5'h00,8'h62,8'h00}, {2'd1,5'h08,8'h00,8'hFF},                            // R1
    {2'd0,5'h01,8'h52,8'h00}, {2'd1,5'h01,8'h00,8'h52}, {2'd0,5'h0F,8'h00,8'h00},  // R2
    {2'd1,5'h10,8'h00,8'h00},                                                      // R3
    {2'd0,5'h00,8'hA2,8'h00}, {2'd1,5'h00,8'h00,8'hA2},                            // R2
    {2'd0,5'h03,8'h77,8'h00}, {2'd1,5'h03,8'h00,8'h77},
    {2'd0,5'h08,8'h55,8'h00}, {2'd1,5'h08,8'h00,8'h00},                            // R3
    {2'd0,5'h00,8'hE2,8'h00}, {2'd0,5'h01,8'hAA,8'h00}, {2'd1,5'h01,8'h00,8'h00},  // R3
    {2'd0,5'h00,8'h22,8'h00}, {2'd1,5'h01,8'h00,8'h46}, {2'd1,5'h03,8'h00,8'h4C},  // R2 R3
    {2'd1,5'h0F,8'h00,8'h00},                                                      // R4
    {2'd0,5'h1F,8'hFF,8'h00}, {2'd1,5'h00,8'h00,8'h22},                            // R9
    {2'd1,5'h1F,8'h00,8'h00}, {2'd1,5'h0F,8'h00,8'h80}, {2'd1,5'h0E,8'h00,8'h00},  // R9
    {2'd1,5'h01,8'h00,8'h00}, {2'd0,5'h00,8'h62,8'h00}, {2'd1,5'h0F,8'h00,8'hFF}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr_en = (op == 2'd0);
    rd_en = (op == 2'd1);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][22:21], VEC[v][20:16], VEC[v][15:8]);
      if (VEC[v][22:21] == 2'd1) chk($sformatf("R1-table vec %0d rdata", v), rdata, VEC[v][7:0]);
      else if (VEC[v][22:21] == 2'd2) chk($sformatf("R5 vec %0d irq", v), irq, VEC[v][0]);
    end
    // R1: hard reset after activity
    drive(2'd0, 5'h0E, 8'h02);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 rdata after reset", rdata, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 tx_go after reset", tx_go, 1'b0);
    drive(2'd1, 5'h00, 8'h00); chk("R1 cmd after reset", rdata, 8'h22);
    // R7 R5 R8: transmit pulse contents and interrupt latency
    drive(2'd0, 5'h0E, 8'h02);
    drive(2'd0, 5'h04, 8'h12);
    drive(2'd0, 5'h05, 8'hEA);
    drive(2'd0, 5'h06, 8'h05);
    @(negedge clk); addr = 5'h00; wdata = 8'h26; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 tx_go pulse", tx_go, 1'b1);
    chk("R7 tx_page", tx_page, 8'h12);
    chk("R8 tx_len", tx_len, 16'h05EA);
    chk("R5 irq not yet", irq, 1'b0);
    @(negedge clk);
    chk("R7 tx_go one cycle", tx_go, 1'b0);
    chk("R5 irq one cycle later", irq, 1'b1);
    // R10: read data holds between reads
    drive(2'd1, 5'h05, 8'h00);
    chk("R10 read value", rdata, 8'hEA);
    drive(2'd0, 5'h05, 8'h11);
    repeat (2) @(negedge clk);
    chk("R10 rdata holds", rdata, 8'hEA);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule